// File: doc/BRIEF.md
# Pipelined Synchronous Burst Static RAM

This block is a synthesizable behavioural model of a static RAM that registers every control input on the rising clock edge and returns read data through one output pipeline register. A word is 36 bits wide, split into four 9-bit byte lanes. The depth is set by the address width parameter. Any access begins with one of two address strobes. The processor strobe always starts a read, and only when the primary select is low. The controller strobe starts a read or a write, depending on the write controls in that same cycle. The three select inputs are sampled only in a cycle that loads an address. A failed select check drops the block into its deselected state.

After a load, the two low address bits act as a linear burst counter that wraps modulo four. The upper bits stay fixed for the whole burst. The counter steps in each cycle where the step input is low. Such a cycle accesses the new address, and it writes if the write decode is active. A cycle with the step input high is a wait state: the address holds, nothing is written, and the held word is read again. An asynchronous active-low output enable gates the data drivers.

The control state machine has three states. ST_DESEL is the deselected state. ST_READ means the last access was a read, and ST_WRITE means it was a write. The transitions are as follows:
- load with a failed select check: to ST_DESEL
- load that writes: to ST_WRITE
- load that reads: to ST_READ
- non-load cycle in ST_READ or ST_WRITE: to ST_WRITE if the cycle writes, otherwise to ST_READ
- non-load cycle in ST_DESEL: stays in ST_DESEL

Top module: `burst_sram`

## Requirements
- R1: With `strb_cpu_n` low and `sel_n` low, the block loads `addr` and reads it, whatever the write controls and `strb_ctl_n` are doing. The word appears on `dq_out` one clock later.
- R2: While `sel_n` is high, `strb_cpu_n` has no effect, and a burst in progress continues.
- R3: A load (an accepted `strb_cpu_n`, or else `strb_ctl_n` low) with `sel_n` high, `sel_hi` low or `sel_lo_n` high deselects the block. From the next clock, `dq_drv` is 0 until the next good load. In non-load cycles the select inputs have no effect.
- R4: In a non-load cycle of an active burst with `step_n` low, address bits [1:0] step linearly modulo 4 (3 is followed by 0). Bits [AW-1:2] keep their loaded value.
- R5: In a non-load cycle with `step_n` high, the address holds, nothing is written, and the same word is read again.
- R6: `wr_all_n` low writes all four lanes, whatever `wr_byte_n` and `lane_we_n` are doing.
- R7: With `wr_byte_n` low, each low bit i of `lane_we_n` writes lane i, which is `wdata[9i+8:9i]`. With `wr_all_n` and `wr_byte_n` both high, nothing is written.
- R8: A controller-strobe load with an active write decode writes `wdata` to `addr` in that same cycle. Later burst writes occur only in cycles with `step_n` low.
- R9: `dq_drv` is high only when `out_en_n` is low and a read result is held. `out_en_n` acts without a clock edge. `dq_out` is 0 whenever `dq_drv` is 0.
- R10: A clock that performs a write, or no access, leaves `dq_drv` at 0 for the following cycle.
- R11: In reset, the block is deselected and `dq_drv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | External word address |
| strb_cpu_n | input | 1 | Processor address strobe, active low, always starts a read |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Primary select, active low |
| sel_hi | input | 1 | Secondary select, active high |
| sel_lo_n | input | 1 | Secondary select, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_byte_n | input | 1 | Per-lane write qualifier, active low |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| wdata | input | 36 | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | 36 | Read data, zero when not driven |
| dq_drv | output | 1 | Data drivers enabled |

## Verification
The hardest situations to reach are the ones where two inputs compete in a single cycle. Examples are a processor strobe that meets active write controls and a low controller strobe together, and a processor strobe that meets a high primary select in the middle of a running burst. The stimulus builds these up in order. First, controller-strobe writes fill the whole array, so every word is known. Then bursts start from a low address of 2, so that the counter wraps inside four steps. Wait and ignored-strobe cycles go inside those bursts, and reads issued later bring back any word a wait or a blocked write could have corrupted.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } acc_state_e;

    localparam int BURST_W = 2;
endpackage

// File: rtl/bsram_wdec.sv
module bsram_wdec #(
    parameter int LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_we_n,
    output logic [LANES-1:0] lane_en,
    output logic             wr_any
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en[g] = !wr_all_n || (!wr_byte_n && !lane_we_n[g]);
    end

    assign wr_any = |lane_en;
endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          strb_cpu_n,
    input  logic          strb_ctl_n,
    input  logic          step_n,
    input  logic          sel_n,
    input  logic          sel_hi,
    input  logic          sel_lo_n,
    input  logic          wr_any,
    output logic [AW-1:0] acc_addr,
    output logic          acc_wr,
    output logic          acc_rd
);
    localparam int HW = AW - BURST_W;

    acc_state_e         state_q, state_d;
    logic [HW-1:0]      hi_q, hi_d;
    logic [BURST_W-1:0] cnt_q, cnt_d, step_cnt;
    logic               cpu_ld, ctl_ld, new_ld, bad_sel;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
            hi_q    <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            hi_q    <= hi_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and access outputs
    always_comb begin
        cpu_ld   = !strb_cpu_n && !sel_n;
        ctl_ld   = !cpu_ld && !strb_ctl_n;
        new_ld   = cpu_ld || ctl_ld;
        bad_sel  = sel_n || !sel_hi || sel_lo_n;
        step_cnt = step_n ? cnt_q : cnt_q + BURST_W'(1);
        state_d  = state_q;
        hi_d     = hi_q;
        cnt_d    = cnt_q;
        acc_addr = '0;
        acc_wr   = 1'b0;
        acc_rd   = 1'b0;
        if (new_ld) begin
            if (bad_sel) begin
                state_d = ST_DESEL;
            end else begin
                acc_addr = addr;
                acc_wr   = ctl_ld && wr_any;
                acc_rd   = !acc_wr;
                hi_d     = addr[AW-1:BURST_W];
                cnt_d    = addr[BURST_W-1:0];
                state_d  = acc_wr ? ST_WRITE : ST_READ;
            end
        end else begin
            unique case (state_q)
                ST_DESEL: begin
                    state_d = ST_DESEL;
                end
                ST_READ, ST_WRITE: begin
                    cnt_d    = step_cnt;
                    acc_addr = {hi_q, step_cnt};
                    acc_wr   = !step_n && wr_any;
                    acc_rd   = !acc_wr;
                    state_d  = acc_wr ? ST_WRITE : ST_READ;
                end
                default: begin
                    state_d = ST_DESEL;
                end
            endcase
        end
    end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           acc_addr,
    input  logic                    acc_wr,
    input  logic                    acc_rd,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] q,
    output logic                    q_valid
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q_l;

        always_ff @(posedge clk) begin
            if (acc_wr && lane_en[g]) begin
                mem[acc_addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_l <= '0;
            end else if (acc_rd) begin
                q_l <= mem[acc_addr];
            end
        end

        assign q[g*LANE_W +: LANE_W] = q_l;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
        end else begin
            q_valid <= acc_rd;
        end
    end
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    strb_cpu_n,
    input  logic                    strb_ctl_n,
    input  logic                    step_n,
    input  logic                    sel_n,
    input  logic                    sel_hi,
    input  logic                    sel_lo_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    out_en_n,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_drv
);
    logic [LANES-1:0]        lane_en;
    logic                    wr_any;
    logic [AW-1:0]           acc_addr;
    logic                    acc_wr, acc_rd, q_valid;
    logic [LANES*LANE_W-1:0] q;

    bsram_wdec #(.LANES(LANES)) wdec_i (
        .wr_all_n (wr_all_n),
        .wr_byte_n(wr_byte_n),
        .lane_we_n(lane_we_n),
        .lane_en  (lane_en),
        .wr_any   (wr_any)
    );

    bsram_ctrl #(.AW(AW)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .strb_cpu_n(strb_cpu_n),
        .strb_ctl_n(strb_ctl_n),
        .step_n    (step_n),
        .sel_n     (sel_n),
        .sel_hi    (sel_hi),
        .sel_lo_n  (sel_lo_n),
        .wr_any    (wr_any),
        .acc_addr  (acc_addr),
        .acc_wr    (acc_wr),
        .acc_rd    (acc_rd)
    );

    bsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_addr(acc_addr),
        .acc_wr  (acc_wr),
        .acc_rd  (acc_rd),
        .lane_en (lane_en),
        .wdata   (wdata),
        .q       (q),
        .q_valid (q_valid)
    );

    assign dq_drv = q_valid && !out_en_n;
    assign dq_out = dq_drv ? q : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strb_cpu_n,
    input logic          strb_ctl_n,
    input logic          sel_n,
    input logic          sel_hi,
    input logic          sel_lo_n,
    input logic          wr_all_n,
    input logic          out_en_n,
    input logic [DW-1:0] dq_out,
    input logic          dq_drv
);
    logic cpu_go, any_ld, sel_ok;
    assign cpu_go = !strb_cpu_n && !sel_n;
    assign any_ld = cpu_go || !strb_ctl_n;
    assign sel_ok = !sel_n && sel_hi && !sel_lo_n;

    AST_CPU_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_go && sel_ok) |=> (dq_drv == !out_en_n)) else $error("cpu read"); // R1

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (any_ld && !sel_ok) |=> !dq_drv) else $error("deselect"); // R3

    AST_CTL_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_go && !strb_ctl_n && sel_ok && !wr_all_n) |=> !dq_drv) else $error("ctl write"); // R8

    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> (!dq_drv && dq_out == '0)) else $error("oe gate"); // R9

    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_drv |-> (dq_out == '0)) else $error("undriven zero"); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!dq_drv || rst_n)) else $error("reset"); // R11
endmodule

bind burst_sram burst_sram_chk #(.DW(LANES*LANE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb_cpu_n(strb_cpu_n),
    .strb_ctl_n(strb_ctl_n),
    .sel_n     (sel_n),
    .sel_hi    (sel_hi),
    .sel_lo_n  (sel_lo_n),
    .wr_all_n  (wr_all_n),
    .out_en_n  (out_en_n),
    .dq_out    (dq_out),
    .dq_drv    (dq_drv)
);

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;
    localparam int AW = 6;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic          strb_cpu_n, strb_ctl_n, step_n, sel_n, sel_hi, sel_lo_n;
    logic          wr_all_n, wr_byte_n, out_en_n;
    logic [3:0]    lane_we_n;
    logic [DW-1:0] wdata, dq_out;
    logic          dq_drv;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    logic [DW-1:0] mm [64];
    bit            m_act = 0, m_valid = 0;
    int            m_base = 0, m_off = 0;
    logic [DW-1:0] m_q = '0;

    always #4 clk = ~clk;

    burst_sram #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .strb_cpu_n(strb_cpu_n),
        .strb_ctl_n(strb_ctl_n), .step_n(step_n), .sel_n(sel_n), .sel_hi(sel_hi),
        .sel_lo_n(sel_lo_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
        .lane_we_n(lane_we_n), .wdata(wdata), .out_en_n(out_en_n),
        .dq_out(dq_out), .dq_drv(dq_drv)
    );

    function automatic logic [DW-1:0] pat(int a, int salt);
        return (DW'(a + 1) * 36'h0_0F1E_2D3B) ^ DW'(salt);
    endfunction

    task automatic check(string tag, logic got_drv, logic [DW-1:0] got_dq,
                         logic exp_drv, logic [DW-1:0] exp_dq);
        n_chk++;
        if (got_drv !== exp_drv || got_dq !== exp_dq) begin
            n_bad++;
            $display("FAIL %s: drv=%0b dq=%h expected drv=%0b dq=%h",
                     tag, got_drv, got_dq, exp_drv, exp_dq);
        end
    endtask

    task automatic quiet();
        addr = '0; strb_cpu_n = 1; strb_ctl_n = 1; step_n = 1;
        sel_n = 0; sel_hi = 1; sel_lo_n = 0;
        wr_all_n = 1; wr_byte_n = 1; lane_we_n = 4'hF; wdata = '0; out_en_n = 0;
    endtask

    task automatic model_edge();
        bit cpu, ctl, bad, acc, wr;
        logic [3:0] len;
        int a_now;
        cpu = !strb_cpu_n && !sel_n;
        ctl = !cpu && !strb_ctl_n;
        bad = sel_n || !sel_hi || sel_lo_n;
        for (int i = 0; i < 4; i++) len[i] = !wr_all_n || (!wr_byte_n && !lane_we_n[i]);
        acc = 0; wr = 0; a_now = 0;
        if (cpu || ctl) begin
            if (bad) m_act = 0;
            else begin
                a_now = int'(addr); m_base = int'(addr); m_off = int'(addr) % 4;
                wr = ctl && (len != 0); acc = 1; m_act = 1;
            end
        end else if (m_act) begin
            if (!step_n) m_off = (m_off + 1) % 4;
            a_now = (m_base / 4) * 4 + m_off;
            wr = !step_n && (len != 0); acc = 1;
        end
        if (acc && wr) begin
            for (int i = 0; i < 4; i++)
                if (len[i]) mm[a_now][i*9 +: 9] = wdata[i*9 +: 9];
            m_valid = 0;
        end else if (acc) begin
            m_q = mm[a_now]; m_valid = 1;
        end else m_valid = 0;
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_edge();
        #2;
        check(tag, dq_drv, dq_out, m_valid && !out_en_n,
              (m_valid && !out_en_n) ? m_q : '0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: drv=%0b dq=%h expected completion", dq_drv, dq_out);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        quiet();
        repeat (3) @(posedge clk);
        #2;
        check("R11", dq_drv, dq_out, 1'b0, '0);
        rst_n = 1;
        tick("R11");

        // fill the whole array with whole-word writes
        for (int a = 0; a < 64; a++) begin
            quiet(); strb_ctl_n = 0; addr = AW'(a); wr_all_n = 0; wdata = pat(a, 0);
            tick("R6");
        end

        // processor strobe reads despite write controls and controller strobe
        quiet(); strb_cpu_n = 0; strb_ctl_n = 0; wr_all_n = 0; addr = 5; wdata = '0;
        tick("R1");
        quiet(); tick("R1");

        // linear burst from low bits 2, wrapping
        quiet(); strb_cpu_n = 0; addr = 6; tick("R4");
        for (int k = 0; k < 4; k++) begin quiet(); step_n = 0; tick("R4"); end
        // wait states with write controls active: no write
        for (int k = 0; k < 2; k++) begin quiet(); wr_all_n = 0; wdata = '1; tick("R5"); end
        // processor strobe with primary select high is ignored
        quiet(); strb_cpu_n = 0; sel_n = 1; addr = 40; step_n = 0; tick("R2");
        quiet(); step_n = 0; tick("R2");

        // controller-strobe byte write, then burst writes
        quiet(); strb_ctl_n = 0; addr = 20; wr_byte_n = 0; lane_we_n = 4'b1010;
        wdata = 36'hA_BCDE_F123; tick("R7");
        quiet(); step_n = 0; wr_all_n = 0; wdata = pat(99, 7); tick("R8");
        quiet(); step_n = 0; wr_byte_n = 1; lane_we_n = 4'h0; wdata = '1; tick("R7");
        quiet(); wr_byte_n = 0; lane_we_n = 4'h0; wdata = '1; tick("R5");
        quiet(); step_n = 0; wr_byte_n = 0; lane_we_n = 4'b0111; wdata = pat(5, 9); tick("R10");
        quiet(); tick("R10");
        // read back every touched word
        for (int a = 0; a < 8; a++) begin
            quiet(); strb_cpu_n = 0; addr = AW'(a < 4 ? 4 + a : 16 + a); tick("R8");
        end

        // deselect on a load, and select inputs ignored between loads
        quiet(); strb_cpu_n = 0; sel_hi = 0; addr = 3; tick("R3");
        quiet(); step_n = 0; tick("R3");
        quiet(); sel_n = 1; step_n = 0; tick("R3");
        quiet(); strb_cpu_n = 0; addr = 9; tick("R1");
        quiet(); sel_lo_n = 1; step_n = 0; tick("R3");
        quiet(); sel_hi = 0; tick("R3");
        quiet(); sel_n = 1; strb_ctl_n = 0; addr = 30; tick("R3");
        quiet(); step_n = 0; tick("R3");
        quiet(); strb_ctl_n = 0; sel_lo_n = 1; addr = 31; tick("R3");
        quiet(); tick("R3");

        // asynchronous output enable
        quiet(); strb_cpu_n = 0; addr = 12; tick("R9");
        quiet();
        out_en_n = 1; #1;
        check("R9", dq_drv, dq_out, 1'b0, '0);
        out_en_n = 0; #1;
        check("R9", dq_drv, dq_out, 1'b1, mm[12]);
        tick("R9");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule